// File: doc/BRIEF.md
# Dual-Issue Pair Hazard Stall Unit

This unit sits between the decode logic and the write-back controls of a two-slot, in-order core built from two single-cycle datapaths. Each cycle it sees both fetched instruction words (the older one in slot A, the younger one in slot B) and the data-memory address computed by each slot. It decides whether slot B may commit in the same cycle as slot A. When it may not, it raises a stall flag and forces slot B's register-write and memory-write enables low, so slot B's result is thrown away. Re-issuing the suppressed instruction is left to the program-counter logic outside this unit.

The unit is purely combinational. It decodes each word into its control class, its memory class, its destination register and up to two source registers. Four checks feed the stall: a control transfer in slot A, a load/store pair that touches the same memory word, a register written by slot A and read by slot B, and a register written by slot B and read by slot A.

Top module: `dual_issue_stall`

## Requirements
- R1: A jump in slot A stalls slot B whatever slot B holds. Jumps are opcode 000010 and 000011 (word bits 31:26), and opcode 000000 with function code 001000 or 001001 (bits 5:0).
- R2: A conditional branch in slot A stalls slot B whatever slot B holds. Branches are opcodes 000100, 000101, 000110, 000111 and 000001.
- R3: When slot A is a load (opcodes 100011, 100001, 100101, 100000, 100100) and slot B is a store (opcodes 101011, 101001, 101000) and both addresses fall in the same word, slot B stalls. Different words give no stall from this rule.
- R4: When slot A is a store and slot B is a load to the same word, slot B stalls. Two loads, or two stores, to the same word do not stall.
- R5: When the register written by slot A is read by slot B, slot B stalls. Register fields are rs at bits 25:21, rt at bits 20:16 and rd at bits 15:11.
- R6: When the register written by slot B is read by slot A, slot B stalls.
- R7: The written register is rd for opcode 000000, rt for immediate ALU ops (opcodes 001000 to 001111) and loads, and register 31 for opcode 000011. Stores, branches and plain jumps write no register.
- R8: Register 0 never causes a stall, neither as source nor as destination.
- R9: Sources are rs and rt for opcode 000000, branches and stores; rs alone for immediate ALU ops and loads; none for opcodes 000010 and 000011. A field that is not a source never causes a stall.
- R10: Addresses are compared with their two low byte-offset bits ignored, so byte and halfword accesses inside one word count as the same address.
- R11: While the stall flag is 1 both slot-B enable outputs are 0; while it is 0 they equal their raw inputs.
- R12: A pair that meets none of the rules above never stalls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_a_i | input | 32 | Instruction word in the older slot (A) |
| instr_b_i | input | 32 | Instruction word in the younger slot (B) |
| addr_a_i | input | 32 | Data-memory byte address computed by slot A |
| addr_b_i | input | 32 | Data-memory byte address computed by slot B |
| wr_reg_b_i | input | 1 | Raw register-write enable of slot B |
| wr_mem_b_i | input | 1 | Raw memory-write enable of slot B |
| stall_b_o | output | 1 | 1 when slot B must be suppressed this cycle |
| wr_reg_b_o | output | 1 | Slot B register-write enable after gating |
| wr_mem_b_o | output | 1 | Slot B memory-write enable after gating |

## Verification
Two stall sources can fire on the same pair: a slot-A store reading a register that slot B overwrites while slot B loads the same word, so the register check and the memory check must both assert the flag without masking each other. The bench builds such pairs, along with pairs that meet exactly one rule and pairs that only nearly meet one (a reused field that is not a source, register 0, the next word), and compares the flag and both gated enables with values worked out from the rules for each pair.

// File: rtl/dis_pkg.sv
package dis_pkg;

    localparam int INSTR_W   = 32;
    localparam int REG_IDX_W = 5;
    localparam int OPC_W     = 6;

    typedef logic [REG_IDX_W-1:0] reg_idx_t;
    typedef logic [OPC_W-1:0]     opc_t;

    localparam reg_idx_t LINK_REG = reg_idx_t'(31);

    // primary opcodes
    localparam opc_t OPC_SPECIAL = 6'b000000;
    localparam opc_t OPC_REGIMM  = 6'b000001;
    localparam opc_t OPC_J       = 6'b000010;
    localparam opc_t OPC_JAL     = 6'b000011;
    localparam opc_t OPC_BEQ     = 6'b000100;
    localparam opc_t OPC_BNE     = 6'b000101;
    localparam opc_t OPC_BLEZ    = 6'b000110;
    localparam opc_t OPC_BGTZ    = 6'b000111;
    localparam opc_t OPC_LB      = 6'b100000;
    localparam opc_t OPC_LH      = 6'b100001;
    localparam opc_t OPC_LW      = 6'b100011;
    localparam opc_t OPC_LBU     = 6'b100100;
    localparam opc_t OPC_LHU     = 6'b100101;
    localparam opc_t OPC_SB      = 6'b101000;
    localparam opc_t OPC_SH      = 6'b101001;
    localparam opc_t OPC_SW      = 6'b101011;

    // function codes under OPC_SPECIAL
    localparam opc_t FN_JR   = 6'b001000;
    localparam opc_t FN_JALR = 6'b001001;

    typedef enum logic [1:0] {
        MEM_NONE  = 2'd0,
        MEM_LOAD  = 2'd1,
        MEM_STORE = 2'd2
    } mem_kind_e;

    typedef struct packed {
        reg_idx_t idx;
        logic     vld;
    } reg_ref_t;

    typedef struct packed {
        logic      xfer;
        mem_kind_e mem;
        reg_ref_t  dst;
        reg_ref_t  src0;
        reg_ref_t  src1;
    } slot_info_t;

    function automatic reg_ref_t mk_ref(input reg_idx_t idx);
        reg_ref_t r;
        r.idx = idx;
        r.vld = 1'b1;
        return r;
    endfunction

    function automatic slot_info_t decode_fields(
        input opc_t     op,
        input opc_t     fn,
        input reg_idx_t rs,
        input reg_idx_t rt,
        input reg_idx_t rd
    );
        slot_info_t s;
        s = '0;
        s.mem = MEM_NONE;
        unique casez (op)
            OPC_SPECIAL: begin
                s.src0 = mk_ref(rs);
                if (fn == FN_JR) begin
                    s.xfer = 1'b1;
                end else if (fn == FN_JALR) begin
                    s.xfer = 1'b1;
                    s.dst  = mk_ref(rd);
                end else begin
                    s.src1 = mk_ref(rt);
                    s.dst  = mk_ref(rd);
                end
            end
            OPC_J: s.xfer = 1'b1;
            OPC_JAL: begin
                s.xfer = 1'b1;
                s.dst  = mk_ref(LINK_REG);
            end
            OPC_REGIMM, OPC_BEQ, OPC_BNE, OPC_BLEZ, OPC_BGTZ: begin
                s.xfer = 1'b1;
                s.src0 = mk_ref(rs);
                s.src1 = mk_ref(rt);
            end
            6'b001???: begin
                s.src0 = mk_ref(rs);
                s.dst  = mk_ref(rt);
            end
            OPC_LB, OPC_LH, OPC_LW, OPC_LBU, OPC_LHU: begin
                s.mem  = MEM_LOAD;
                s.src0 = mk_ref(rs);
                s.dst  = mk_ref(rt);
            end
            OPC_SB, OPC_SH, OPC_SW: begin
                s.mem  = MEM_STORE;
                s.src0 = mk_ref(rs);
                s.src1 = mk_ref(rt);
            end
            default: s = '0;
        endcase
        return s;
    endfunction

    // a written register meets a read register, register 0 excluded
    function automatic logic ref_hit(input reg_ref_t wr, input reg_ref_t rd_ref);
        return wr.vld && rd_ref.vld && (wr.idx != '0) && (wr.idx == rd_ref.idx);
    endfunction

endpackage

// File: rtl/dis_slot_decode.sv
module dis_slot_decode
    import dis_pkg::*;
#(
    parameter int WORD_W = INSTR_W
) (
    input  logic [WORD_W-1:0] word_i,
    output slot_info_t        info_o
);
    localparam int OP_LSB = WORD_W - OPC_W;
    localparam int RS_LSB = OP_LSB - REG_IDX_W;
    localparam int RT_LSB = RS_LSB - REG_IDX_W;
    localparam int RD_LSB = RT_LSB - REG_IDX_W;

    logic unused_shamt;
    assign unused_shamt = ^word_i[RD_LSB-1:OPC_W];

    assign info_o = decode_fields(
        word_i[WORD_W-1:OP_LSB],
        word_i[OPC_W-1:0],
        word_i[OP_LSB-1:RS_LSB],
        word_i[RS_LSB-1:RT_LSB],
        word_i[RT_LSB-1:RD_LSB]
    );
endmodule

// File: rtl/dis_reg_dep.sv
module dis_reg_dep
    import dis_pkg::*;
(
    input  slot_info_t older_i,
    input  slot_info_t younger_i,
    output logic       fwd_dep_o,
    output logic       back_dep_o
);
    // older writes, younger reads
    assign fwd_dep_o  = ref_hit(older_i.dst, younger_i.src0)
                      | ref_hit(older_i.dst, younger_i.src1);
    // younger writes, older reads
    assign back_dep_o = ref_hit(younger_i.dst, older_i.src0)
                      | ref_hit(younger_i.dst, older_i.src1);
endmodule

// File: rtl/dis_mem_conflict.sv
module dis_mem_conflict
    import dis_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  mem_kind_e          kind_a_i,
    input  mem_kind_e          kind_b_i,
    input  logic [ADDR_W-1:0]  addr_a_i,
    input  logic [ADDR_W-1:0]  addr_b_i,
    output logic               clash_o
);
    localparam int WORD_LSB = $clog2(DATA_W / 8);

    logic unused_ofs;
    logic same_word;
    logic ld_then_st;
    logic st_then_ld;

    assign unused_ofs = ^{addr_a_i[WORD_LSB-1:0], addr_b_i[WORD_LSB-1:0]};
    assign same_word  = (addr_a_i[ADDR_W-1:WORD_LSB] == addr_b_i[ADDR_W-1:WORD_LSB]);
    assign ld_then_st = (kind_a_i == MEM_LOAD)  && (kind_b_i == MEM_STORE);
    assign st_then_ld = (kind_a_i == MEM_STORE) && (kind_b_i == MEM_LOAD);
    assign clash_o    = same_word && (ld_then_st || st_then_ld);
endmodule

// File: rtl/dual_issue_stall.sv
module dual_issue_stall
    import dis_pkg::*;
#(
    parameter int WORD_W = INSTR_W,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic [WORD_W-1:0] instr_a_i,
    input  logic [WORD_W-1:0] instr_b_i,
    input  logic [ADDR_W-1:0] addr_a_i,
    input  logic [ADDR_W-1:0] addr_b_i,
    input  logic              wr_reg_b_i,
    input  logic              wr_mem_b_i,
    output logic              stall_b_o,
    output logic              wr_reg_b_o,
    output logic              wr_mem_b_o
);
    localparam int N_SLOTS = 2;

    logic [WORD_W-1:0] words [N_SLOTS];
    slot_info_t        info  [N_SLOTS];

    assign words[0] = instr_a_i;
    assign words[1] = instr_b_i;

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_dec
        dis_slot_decode #(.WORD_W(WORD_W)) u_dec (
            .word_i (words[g]),
            .info_o (info[g])
        );
    end

    logic fwd_dep;
    logic back_dep;
    logic mem_clash;
    logic xfer_a;

    dis_reg_dep u_dep (
        .older_i    (info[0]),
        .younger_i  (info[1]),
        .fwd_dep_o  (fwd_dep),
        .back_dep_o (back_dep)
    );

    dis_mem_conflict #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .kind_a_i (info[0].mem),
        .kind_b_i (info[1].mem),
        .addr_a_i (addr_a_i),
        .addr_b_i (addr_b_i),
        .clash_o  (mem_clash)
    );

    logic unused_b_xfer;
    assign unused_b_xfer = info[1].xfer;

    assign xfer_a     = info[0].xfer;
    assign stall_b_o  = xfer_a | mem_clash | fwd_dep | back_dep;
    assign wr_reg_b_o = wr_reg_b_i & ~stall_b_o;
    assign wr_mem_b_o = wr_mem_b_i & ~stall_b_o;
endmodule

// File: rtl/dis_stall_chk.sv
module dis_stall_chk
    import dis_pkg::*;
(
    input logic [OPC_W-1:0] op_a,
    input logic [OPC_W-1:0] op_b,
    input logic [29:0]      word_a,
    input logic [29:0]      word_b,
    input logic             wr_reg_b_i,
    input logic             wr_mem_b_i,
    input logic             stall_b_o,
    input logic             wr_reg_b_o,
    input logic             wr_mem_b_o
);
    logic a_load, b_store, a_store, b_load;
    assign a_load  = (op_a == OPC_LW) || (op_a == OPC_LH) || (op_a == OPC_LHU)
                  || (op_a == OPC_LB) || (op_a == OPC_LBU);
    assign a_store = (op_a == OPC_SW) || (op_a == OPC_SH) || (op_a == OPC_SB);
    assign b_load  = (op_b == OPC_LW) || (op_b == OPC_LH) || (op_b == OPC_LHU)
                  || (op_b == OPC_LB) || (op_b == OPC_LBU);
    assign b_store = (op_b == OPC_SW) || (op_b == OPC_SH) || (op_b == OPC_SB);

    always_comb begin
        // R11
        gate_off_chk: assert (!stall_b_o || (!wr_reg_b_o && !wr_mem_b_o))
            else $error("gated enables high during stall");
        // R11
        gate_pass_chk: assert (stall_b_o || (wr_reg_b_o == wr_reg_b_i && wr_mem_b_o == wr_mem_b_i))
            else $error("enables altered without stall");
        // R1
        jump_stall_chk: assert (!(op_a == OPC_J || op_a == OPC_JAL) || stall_b_o)
            else $error("jump in slot A did not stall");
        // R2
        branch_stall_chk: assert (!(op_a == OPC_BEQ || op_a == OPC_BNE || op_a == OPC_BLEZ
                                    || op_a == OPC_BGTZ || op_a == OPC_REGIMM) || stall_b_o)
            else $error("branch in slot A did not stall");
        // R3
        ld_st_stall_chk: assert (!(a_load && b_store && word_a == word_b) || stall_b_o)
            else $error("load/store same word did not stall");
        // R4
        st_ld_stall_chk: assert (!(a_store && b_load && word_a == word_b) || stall_b_o)
            else $error("store/load same word did not stall");
    end
endmodule

bind dual_issue_stall dis_stall_chk u_chk (
    .op_a       (instr_a_i[31:26]),
    .op_b       (instr_b_i[31:26]),
    .word_a     (addr_a_i[31:2]),
    .word_b     (addr_b_i[31:2]),
    .wr_reg_b_i (wr_reg_b_i),
    .wr_mem_b_i (wr_mem_b_i),
    .stall_b_o  (stall_b_o),
    .wr_reg_b_o (wr_reg_b_o),
    .wr_mem_b_o (wr_mem_b_o)
);

// File: tb/dual_issue_stall_test.sv
`timescale 1ns/1ps
module dual_issue_stall_test;

    logic        clk = 1'b0;
    logic [31:0] instr_a = '0, instr_b = '0, addr_a = '0, addr_b = '0;
    logic        wr_reg_in = 1'b0, wr_mem_in = 1'b0;
    logic        stall, wr_reg_out, wr_mem_out;

    always #5 clk = ~clk;

    dual_issue_stall uut (
        .instr_a_i  (instr_a),
        .instr_b_i  (instr_b),
        .addr_a_i   (addr_a),
        .addr_b_i   (addr_b),
        .wr_reg_b_i (wr_reg_in),
        .wr_mem_b_i (wr_mem_in),
        .stall_b_o  (stall),
        .wr_reg_b_o (wr_reg_out),
        .wr_mem_b_o (wr_mem_out)
    );

    typedef struct {
        logic  st;
        logic  wr;
        logic  wm;
        string tag;
    } exp_t;

    exp_t sb_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 0;

    function automatic logic [31:0] rt_op(input int rs, rt, rd, input logic [5:0] fn);
        return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'b0, fn};
    endfunction
    function automatic logic [31:0] it_op(input logic [5:0] op, input int rs, rt, input int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    localparam logic [5:0] FN_ADD = 6'b100000, FN_SUB = 6'b100010,
                           FN_JR = 6'b001000, FN_JALR = 6'b001001;
    localparam logic [5:0] J = 6'b000010, JAL = 6'b000011, BEQ = 6'b000100, BNE = 6'b000101,
                           BLEZ = 6'b000110, BGTZ = 6'b000111, BLTZ = 6'b000001,
                           ADDI = 6'b001000, ORI = 6'b001101, LW = 6'b100011, LH = 6'b100001,
                           LB = 6'b100000, SW = 6'b101011, SB = 6'b101000;

    task automatic drive(input logic [31:0] ia, ib, aa, ab, input logic wr, wm,
                         input logic exp_st, input string tag);
        exp_t e;
        @(posedge clk);
        instr_a   <= ia;
        instr_b   <= ib;
        addr_a    <= aa;
        addr_b    <= ab;
        wr_reg_in <= wr;
        wr_mem_in <= wm;
        e.st  = exp_st;
        e.wr  = exp_st ? 1'b0 : wr;
        e.wm  = exp_st ? 1'b0 : wm;
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    // monitor: samples at the falling edge
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_checks++;
            if (stall !== e.st || wr_reg_out !== e.wr || wr_mem_out !== e.wm) begin
                n_fail++;
                $display("FAIL %s: got stall=%b wr_reg=%b wr_mem=%b expected stall=%b wr_reg=%b wr_mem=%b",
                         e.tag, stall, wr_reg_out, wr_mem_out, e.st, e.wr, e.wm);
            end
        end
    end

    initial begin
        // idle pair of no-ops after start-up: R12
        drive(32'h0, 32'h0, 32'h0, 32'h0, 1'b1, 1'b1, 1'b0, "R12 idle no-op pair");
        // R1 jumps
        drive({J, 26'h0}, rt_op(1, 2, 3, FN_ADD), 0, 0, 1, 1, 1'b1, "R1 j");
        drive({JAL, 26'h10}, rt_op(1, 2, 3, FN_ADD), 0, 0, 1, 0, 1'b1, "R1 jal");
        drive(rt_op(5, 0, 0, FN_JR), it_op(ADDI, 6, 7, 1), 0, 0, 1, 1, 1'b1, "R1 jr");
        drive(rt_op(5, 0, 9, FN_JALR), it_op(ADDI, 6, 7, 1), 0, 0, 1, 1, 1'b1, "R1 jalr");
        // R2 branches
        drive(it_op(BEQ, 1, 2, 4), it_op(ADDI, 6, 7, 1), 0, 0, 1, 1, 1'b1, "R2 beq");
        drive(it_op(BNE, 1, 2, 4), it_op(ADDI, 6, 7, 1), 0, 0, 1, 1, 1'b1, "R2 bne");
        drive(it_op(BLEZ, 1, 0, 4), it_op(ADDI, 6, 7, 1), 0, 0, 1, 1, 1'b1, "R2 blez");
        drive(it_op(BLTZ, 1, 0, 4), it_op(ADDI, 6, 7, 1), 0, 0, 1, 1, 1'b1, "R2 bltz");
        drive(it_op(BGTZ, 1, 0, 4), it_op(ADDI, 6, 7, 1), 0, 0, 1, 1, 1'b1, "R2 bgtz");
        // R3 load then store
        drive(it_op(LW, 1, 2, 0), it_op(SW, 3, 4, 0), 32'h40, 32'h40, 0, 1, 1'b1, "R3 lw/sw same word");
        drive(it_op(LW, 1, 2, 0), it_op(SW, 3, 4, 0), 32'h40, 32'h44, 0, 1, 1'b0, "R3 lw/sw next word");
        // R4 store then load, and same-kind pairs
        drive(it_op(SW, 1, 2, 0), it_op(LW, 3, 4, 0), 32'h80, 32'h80, 1, 0, 1'b1, "R4 sw/lw same word");
        drive(it_op(LW, 1, 2, 0), it_op(LW, 3, 4, 0), 32'h80, 32'h80, 1, 0, 1'b0, "R4 lw/lw no stall");
        drive(it_op(SW, 1, 2, 0), it_op(SW, 3, 4, 0), 32'h80, 32'h80, 0, 1, 1'b0, "R4 sw/sw no stall");
        // R10 byte offsets inside one word
        drive(it_op(SW, 1, 2, 0), it_op(LH, 3, 4, 2), 32'h80, 32'h82, 1, 0, 1'b1, "R10 sw/lh same word");
        drive(it_op(LB, 1, 2, 3), it_op(SB, 3, 5, 0), 32'h103, 32'h100, 0, 1, 1'b1, "R10 lb/sb same word");
        // R5 / R6 register dependencies
        drive(rt_op(1, 2, 3, FN_ADD), rt_op(3, 4, 5, FN_SUB), 0, 0, 1, 0, 1'b1, "R5 A writes r3 B reads");
        drive(rt_op(8, 7, 6, FN_ADD), rt_op(1, 2, 8, FN_ADD), 0, 0, 1, 0, 1'b1, "R6 B writes r8 A reads");
        // R8 register 0
        drive(rt_op(1, 2, 0, FN_ADD), rt_op(0, 0, 4, FN_ADD), 0, 0, 1, 0, 1'b0, "R8 r0 dest/src");
        drive(rt_op(0, 0, 4, FN_ADD), it_op(ADDI, 5, 0, 1), 0, 0, 1, 0, 1'b0, "R8 B writes r0");
        // R9 source decoding
        drive(it_op(ADDI, 1, 9, 1), it_op(SW, 2, 9, 0), 32'h0, 32'h40, 0, 1, 1'b1, "R9 store reads rt");
        drive(it_op(ADDI, 1, 9, 1), it_op(ADDI, 3, 9, 1), 0, 0, 1, 0, 1'b0, "R9 addi rt not source");
        drive(it_op(ADDI, 1, 10, 1), {J, 5'd10, 21'h0}, 0, 0, 0, 0, 1'b0, "R9 j reads nothing");
        drive(it_op(LW, 1, 11, 0), it_op(ADDI, 12, 11, 0), 32'h40, 0, 1, 0, 1'b0, "R9 load rt not read in B");
        // R7 destination choice
        drive(rt_op(31, 2, 4, FN_ADD), {JAL, 26'h0}, 0, 0, 1, 0, 1'b1, "R7 jal writes r31");
        drive(it_op(ORI, 1, 12, 5), rt_op(12, 2, 13, FN_ADD), 0, 0, 1, 0, 1'b1, "R7 ori writes rt");
        drive(rt_op(1, 2, 5, FN_ADD), it_op(ADDI, 2, 20, 1), 0, 0, 1, 0, 1'b0, "R7 R-type rt not dest");
        // two rules at once: back dependency plus store/load clash
        drive(it_op(SW, 1, 7, 0), it_op(LW, 2, 7, 0), 32'h200, 32'h201, 1, 0, 1'b1, "R6 R4 combined");
        // R11 pass-through patterns
        drive(rt_op(1, 2, 3, FN_ADD), rt_op(4, 5, 6, FN_ADD), 0, 0, 1, 0, 1'b0, "R11 pass 10");
        drive(rt_op(1, 2, 3, FN_ADD), it_op(SW, 4, 5, 0), 0, 32'h40, 0, 1, 1'b0, "R11 pass 01");
        drive({J, 26'h0}, 32'h0, 0, 0, 0, 0, 1'b1, "R11 stall with low enables");
        // R12 independent mix
        drive(it_op(LW, 1, 2, 0), rt_op(3, 4, 5, FN_ADD), 32'h40, 32'h40, 1, 0, 1'b0, "R12 lw + add");
        drive(it_op(SW, 1, 2, 0), it_op(LW, 3, 4, 0), 32'h10, 32'h20, 1, 0, 1'b0, "R12 sw + lw other word");
        repeat (3) @(posedge clk);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule